// File: doc/BRIEF.md
# Segmented Bypassable Arbiter PUF Model

This block is a synthesizable behavioural model of an arbiter-style physically unclonable function. It gives a detection flow something to exercise in simulation. A chain of 64 switch stages carries two racing paths, and each stage is steered by one challenge bit. Real analogue race timing cannot be simulated, so every stage adds a fixed, signed delay mismatch that is computed at elaboration from a seed parameter. The arbiter at the end of the chain decides which path arrived first.

The stages are grouped into 16 sets of four, and each set can be skipped as a whole. A final output select chooses between the full-chain arbiter decision and a second tap, which is the same race judged at the middle of the chain (after set 7). The caller presents a challenge, a skip mask and the select, then pulses `start`. The response appears one cycle later, marked by a single-cycle valid pulse.

The block has no back-pressure. A `start` is accepted in every cycle, including back to back. Each accepted `start` produces exactly one valid cycle, and the consumer must take it in that cycle.

Top module: `puf_arbiter_chain`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `resp` and `resp_valid` are 0.
- R2: `resp_valid` is 1 in exactly the cycle after each cycle in which `start` was sampled high, and 0 in every other cycle.
- R3: The race is tracked as D = bottom-path delay minus top-path delay, starting at 0. Stage i with challenge bit `chal[i]`=0 passes straight, giving D := D + S(i,0). With `chal[i]`=1 the paths cross, giving D := -D + S(i,1). Here S(i,k) = ((37*i + 11*k + SEED) mod 61) - 30.
- R4: The arbiter decision Q is 1 when the final D < 0, which means the bottom path arrives first. It is 0 otherwise, including a tie.
- R5: When `skip_mask[j]`=1, stages 4j to 4j+3 are skipped. They add nothing, they do not swap, and their challenge bits have no effect on the response.
- R6: When `out_sel_q`=1 the response is Q. When it is 0 the response is the mid tap, which is 1 when D taken after stage 31 (sets 0 to 7 only) is < 0.
- R7: With every set skipped, the response is 0 whatever the challenge and select.
- R8: `resp` keeps its value in every cycle without `start`. Inputs that change without `start` do not alter it.
- R9: The same challenge, mask and select always produce the same response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Evaluate the presented challenge in this cycle |
| chal | input | 64 | Challenge, one bit per switch stage |
| skip_mask | input | 16 | One bit per set of four stages; 1 skips that set |
| out_sel_q | input | 1 | 1 selects the full-chain arbiter decision, 0 the mid tap |
| resp | output | 1 | Registered response bit |
| resp_valid | output | 1 | One-cycle pulse marking a new response |

## Verification
Two functions can fall in the same cycle: a new `start` can be accepted while the previous response is being presented with its valid pulse. The bench provokes this with starts on consecutive cycles that change the mask, the challenge and the select each time. A behavioural delay model in the bench computes the expected valid and response for every cycle, so a response that leaks between neighbouring evaluations, or a missing or merged valid pulse, shows up as a mismatch in that cycle.

// File: rtl/puf_pkg.sv
package puf_pkg;

  // Signed mismatch that stage idx adds in straight (crossed=0) or crossed (crossed=1) state.
  function automatic int stage_skew(input int seed, input int idx, input int crossed);
    int raw;
    raw = (37 * idx + 11 * crossed + seed) % 61;
    return raw - 30;
  endfunction

  typedef enum logic {
    PICK_TAP = 1'b0,
    PICK_Q   = 1'b1
  } out_pick_e;

endpackage

// File: rtl/puf_switch_stage.sv
module puf_switch_stage #(
  parameter int DW   = 16,
  parameter int IDX  = 0,
  parameter int SEED = 7
) (
  input  logic signed [DW-1:0] d_in,
  input  logic                 cross_en,
  output logic signed [DW-1:0] d_out
);
  localparam logic signed [DW-1:0] SK_STRAIGHT = DW'(puf_pkg::stage_skew(SEED, IDX, 0));
  localparam logic signed [DW-1:0] SK_CROSSED  = DW'(puf_pkg::stage_skew(SEED, IDX, 1));

  logic signed [DW-1:0] via_straight;
  logic signed [DW-1:0] via_crossed;

  // Straight: both paths keep their lanes, each lane gains its own delay.
  assign via_straight = d_in + SK_STRAIGHT;
  // Crossed: lanes swap, so the accumulated difference flips sign.
  assign via_crossed  = SK_CROSSED - d_in;

  assign d_out = cross_en ? via_crossed : via_straight;
endmodule

// File: rtl/puf_stage_set.sv
module puf_stage_set #(
  parameter int DW      = 16,
  parameter int SET_LEN = 4,
  parameter int BASE    = 0,
  parameter int SEED    = 7
) (
  input  logic signed [DW-1:0] d_in,
  input  logic [SET_LEN-1:0]   ctrl,
  input  logic                 skip,
  output logic signed [DW-1:0] d_out
);
  logic signed [DW-1:0] link [SET_LEN+1];

  assign link[0] = d_in;

  for (genvar k = 0; k < SET_LEN; k++) begin : g_stage
    puf_switch_stage #(
      .DW  (DW),
      .IDX (BASE + k),
      .SEED(SEED)
    ) u_stage (
      .d_in    (link[k]),
      .cross_en(ctrl[k]),
      .d_out   (link[k+1])
    );
  end

  // Skip pair: both lanes route around the set untouched.
  assign d_out = skip ? d_in : link[SET_LEN];
endmodule

// File: rtl/puf_race_judge.sv
module puf_race_judge #(
  parameter int DW = 16
) (
  input  logic signed [DW-1:0] d_full,
  input  logic signed [DW-1:0] d_mid,
  input  logic                 pick,
  output logic                 q_full,
  output logic                 q_mid,
  output logic                 resp_next
);
  // Bottom path first means bottom delay is smaller: difference negative. Tie gives 0.
  assign q_full = (d_full < 0);
  assign q_mid  = (d_mid  < 0);

  always_comb begin
    unique case (puf_pkg::out_pick_e'(pick))
      puf_pkg::PICK_Q:   resp_next = q_full;
      puf_pkg::PICK_TAP: resp_next = q_mid;
      default:           resp_next = 1'b0;
    endcase
  end
endmodule

// File: rtl/puf_arbiter_chain.sv
module puf_arbiter_chain #(
  parameter int N_STAGES = 64,
  parameter int SET_LEN  = 4,
  parameter int DW       = 16,
  parameter int SEED     = 7
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           start,
  input  logic [N_STAGES-1:0]            chal,
  input  logic [N_STAGES/SET_LEN-1:0]    skip_mask,
  input  logic                           out_sel_q,
  output logic                           resp,
  output logic                           resp_valid
);
  localparam int N_SETS  = N_STAGES / SET_LEN;
  localparam int TAP_SET = N_SETS / 2;

  logic signed [DW-1:0] seg [N_SETS+1];
  logic q_full, q_mid, resp_next;

  assign seg[0] = '0;

  for (genvar s = 0; s < N_SETS; s++) begin : g_set
    puf_stage_set #(
      .DW     (DW),
      .SET_LEN(SET_LEN),
      .BASE   (s * SET_LEN),
      .SEED   (SEED)
    ) u_set (
      .d_in (seg[s]),
      .ctrl (chal[s*SET_LEN +: SET_LEN]),
      .skip (skip_mask[s]),
      .d_out(seg[s+1])
    );
  end

  puf_race_judge #(.DW(DW)) u_judge (
    .d_full   (seg[N_SETS]),
    .d_mid    (seg[TAP_SET]),
    .pick     (out_sel_q),
    .q_full   (q_full),
    .q_mid    (q_mid),
    .resp_next(resp_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      resp       <= 1'b0;
      resp_valid <= 1'b0;
    end else begin
      resp_valid <= start;
      if (start) resp <= resp_next;
    end
  end
endmodule

// File: rtl/puf_arbiter_chain_chk.sv
module puf_arbiter_chain_chk #(
  parameter int N_STAGES = 64,
  parameter int SET_LEN  = 4
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        start,
  input logic [N_STAGES-1:0]         chal,
  input logic [N_STAGES/SET_LEN-1:0] skip_mask,
  input logic                        out_sel_q,
  input logic                        resp,
  input logic                        resp_valid
);
  // R2
  valid_after_start_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> resp_valid);

  // R2
  no_stray_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !start |=> !resp_valid);

  // R8
  resp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !start |=> $stable(resp));

  // R7
  all_skipped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (start && (&skip_mask)) |=> !resp);

  // R9
  repeat_same_chk: assert property (@(posedge clk) disable iff (rst)
    (start && $past(start) && !$past(rst) && $stable(chal) && $stable(skip_mask)
     && $stable(out_sel_q)) |=> $stable(resp));
endmodule

bind puf_arbiter_chain puf_arbiter_chain_chk #(
  .N_STAGES(N_STAGES),
  .SET_LEN (SET_LEN)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .chal      (chal),
  .skip_mask (skip_mask),
  .out_sel_q (out_sel_q),
  .resp      (resp),
  .resp_valid(resp_valid)
);

// File: tb/puf_arbiter_chain_tb.sv
module puf_arbiter_chain_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SEED_TB    = 7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [63:0] chal = '0;
  logic [15:0] skip_mask = '0;
  logic        out_sel_q = 1'b1;
  logic        resp;
  logic        resp_valid;

  int    n_tests = 0;
  int    n_fail  = 0;
  int    cycles  = 0;
  string cur_req = "R3,R4";
  logic  exp_resp = 1'b0;
  logic  exp_valid = 1'b0;
  bit    checking = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  puf_arbiter_chain #(.SEED(SEED_TB)) u_dut (
    .clk(clk), .rst(rst), .start(start), .chal(chal),
    .skip_mask(skip_mask), .out_sel_q(out_sel_q),
    .resp(resp), .resp_valid(resp_valid)
  );

  function automatic int sk(input int i, input int c);
    return ((37 * i + 11 * c + SEED_TB) % 61) - 30;
  endfunction

  // Behavioural race: delay difference after the first nsets sets.
  function automatic int race(input logic [63:0] ch, input logic [15:0] mk, input int nsets);
    int d = 0;
    for (int s = 0; s < nsets; s++) begin
      if (!mk[s]) begin
        for (int k = 0; k < 4; k++) begin
          int i = 4 * s + k;
          if (ch[i]) d = sk(i, 1) - d;
          else       d = d + sk(i, 0);
        end
      end
    end
    return d;
  endfunction

  function automatic logic model_resp(input logic [63:0] ch, input logic [15:0] mk, input logic sel);
    return sel ? (race(ch, mk, 16) < 0) : (race(ch, mk, 8) < 0);
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // Reference model advances on every rising edge.
  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      exp_valid = 1'b0;
      exp_resp  = 1'b0;
    end else begin
      exp_valid = start;
      if (start) exp_resp = model_resp(chal, skip_mask, out_sel_q);
    end
  end

  // Compare on every clock, away from the active edge.
  always @(negedge clk) begin
    if (checking) begin
      check("R2", resp_valid, exp_valid);
      check(cur_req, resp, exp_resp);
    end
  end

  task automatic fire(input logic [63:0] ch, input logic [15:0] mk, input logic sel);
    chal = ch; skip_mask = mk; out_sel_q = sel; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic first_r;
    logic [63:0] base_ch;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", resp, 1'b0);
    check("R1", resp_valid, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", resp, 1'b0);
    check("R1", resp_valid, 1'b0);
    checking = 1'b1;

    // R3, R4: full chain, assorted challenges
    cur_req = "R3,R4";
    fire(64'h0, 16'h0, 1'b1);
    fire(64'hFFFF_FFFF_FFFF_FFFF, 16'h0, 1'b1);
    fire(64'hAAAA_5555_F0F0_0F0F, 16'h0, 1'b1);
    for (int n = 0; n < 40; n++) begin
      fire({$urandom, $urandom}, 16'h0, 1'b1);
      @(negedge clk);
    end

    // R6: mid tap versus full decision
    cur_req = "R6";
    for (int n = 0; n < 30; n++) fire({$urandom, $urandom}, 16'h0, n[0]);

    // R5: skipped sets, challenge bits inside them flipped
    cur_req = "R5";
    for (int n = 0; n < 30; n++) begin
      logic [15:0] mk = 16'($urandom);
      base_ch = {$urandom, $urandom};
      fire(base_ch, mk, 1'b1);
      for (int s = 0; s < 16; s++)
        if (mk[s]) base_ch[4*s +: 4] = ~base_ch[4*s +: 4];
      fire(base_ch, mk, 1'b1);
      fire(base_ch, mk, 1'b0);
    end

    // R7: everything skipped
    cur_req = "R7";
    fire(64'hFFFF_FFFF_FFFF_FFFF, 16'hFFFF, 1'b1);
    check("R7", resp, 1'b0);
    fire(64'h1234_5678_9ABC_DEF0, 16'hFFFF, 1'b0);
    check("R7", resp, 1'b0);

    // R8: inputs wander without start
    cur_req = "R8";
    fire(64'hC3C3_3C3C_9696_6969, 16'h0, 1'b1);
    first_r = resp;
    for (int n = 0; n < 12; n++) begin
      chal = {$urandom, $urandom}; skip_mask = 16'($urandom); out_sel_q = n[0];
      @(negedge clk);
      check("R8", resp, first_r);
    end

    // R9: repeat an earlier evaluation after others
    cur_req = "R9";
    base_ch = 64'h0F1E_2D3C_4B5A_6978;
    fire(base_ch, 16'h0810, 1'b1);
    first_r = resp;
    fire(~base_ch, 16'h0, 1'b0);
    fire(base_ch, 16'h0810, 1'b1);
    check("R9", resp, first_r);

    @(negedge clk);
    @(negedge clk);
    checking = 1'b0;
    finish_run();
  end
endmodule